// File: doc/BRIEF.md
# Big-Integer Operand Order Converter

This block sits between a big-endian host memory image and a 64-bit little-endian big-number arithmetic engine. The host delivers an operand as a stream of 64-bit words in memory order, with a byte length presented alongside the first word. The converter stores the whole operand and then replays it as the engine needs it: the least significant 64-bit word comes first, and the bytes inside each word are reversed. Across the whole operand this is a complete byte reversal. When the length is not a multiple of eight, the missing bytes appear as zeros at the high end of the most significant output word.

On both buses, the byte that comes first in memory order occupies bits [63:56] of the word. On the input side, the last word of an operand whose length is not a multiple of eight carries its valid bytes in the high lanes. Its low lanes are don't-care. Two operand buffers allow one operand to be loaded while the previous one is emitted. A length of zero, or a length above the buffer capacity, sets a sticky error flag. The words of such an operand are consumed and dropped.

Top module: `opconv_top`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err is 0.
- R2: For a byte length L that is a multiple of 8, the converter emits L/8 words. Output word w is input word (L/8-1-w) with its eight bytes in reverse order.
- R3: For any L from 1 to 256, the output byte stream (bits [63:56] first) is the input byte string reversed, followed by zero bytes up to a multiple of 8. Input pad lanes have no effect on it. Example: L=13 with bytes 12 ab cd ef 12 34 56 78 9a bc de f0 f1 gives the words 0xf1f0debc9a785634 and then 0x12efcdab12000000.
- R4: Each operand yields ceil(L/8) output words. out_last is 1 only on the final word, and out_valid stays high between the words of one operand.
- R5: out_valid stays 0 while an operand is being loaded into an empty converter. It rises only after the word marked in_last has been accepted.
- R6: Two operands can be held at once. While both buffers hold operands, in_ready is 0. It returns to 1 once the older operand's last word has been taken.
- R7: An operand whose length (sampled with its first word) is 0 or greater than 256 sets err. err stays 1 until reset, no output is produced for that operand, and its words are still accepted.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values.
- R9: The largest operand, 256 bytes (32 words), is buffered and reversed in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Converter can accept an input word |
| in_data | input | 64 | Input word, first memory byte in [63:56] |
| in_last | input | 1 | Marks the final word of an operand |
| in_len | input | 9 | Operand length in bytes, sampled with the first word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Engine accepts the output word |
| out_data | output | 64 | Output word, first byte sent in [63:56] |
| out_last | output | 1 | Marks the final output word of an operand |
| err | output | 1 | Sticky illegal-length flag |

## Verification
The bench covers lengths with every remainder modulo eight, including 1 byte and a full 256 bytes. Input pad lanes are filled with a non-zero pattern. A design that picked the wrong byte window when the length is unaligned would leak those pad bytes into the output or shift the integer by a few bytes. A design that forgot to mask the word below word zero would place stale buffer data where zeros belong.

Two operands are queued behind a stalled output. This exposes a design that overwrites a buffer still being read, or that lets data move during a stall. The illegal lengths 0 and 300 are sent between good operands. A design that let them reach the output, lost the error flag, or stopped accepting input afterwards would fail.

// File: rtl/opconv_pkg.sv
package opconv_pkg;
    localparam int WORD_BITS  = 64;
    localparam int WORD_BYTES = WORD_BITS / 8;

    typedef logic [WORD_BITS-1:0] word_t;

    // Mirror the byte lanes of one word.
    function automatic word_t byte_rev(input word_t w);
        word_t r;
        for (int i = 0; i < WORD_BYTES; i++) begin
            r[8*i +: 8] = w[WORD_BITS-8-8*i +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/opconv_fill.sv
module opconv_fill
    import opconv_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int LEN_W     = 9,
    parameter int AW        = 5,
    parameter int CW        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  word_t            in_data,
    input  logic             in_last,
    input  logic [LEN_W-1:0] in_len,
    input  logic [1:0]       bank_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [AW-1:0]    wr_addr,
    output word_t            wr_data,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len,
    output logic             err
);
    localparam int MAX_BYTES = MAX_WORDS * WORD_BYTES;

    typedef struct packed {
        logic             bank;
        logic [CW-1:0]    idx;
        logic [LEN_W-1:0] len;
        logic             drop;
        logic             err;
    } fill_t;

    fill_t            fill_q, fill_d;
    logic             fire;
    logic             first;
    logic [LEN_W-1:0] len_eff;
    logic             drop_eff;

    always_comb begin
        fill_d     = fill_q;
        in_ready   = !bank_full[fill_q.bank];
        fire       = in_valid && in_ready;
        first      = (fill_q.idx == '0);
        len_eff    = first ? in_len : fill_q.len;
        drop_eff   = first ? ((in_len == '0) || (in_len > LEN_W'(MAX_BYTES))) : fill_q.drop;
        wr_en      = fire && !drop_eff && (fill_q.idx < CW'(MAX_WORDS));
        wr_bank    = fill_q.bank;
        wr_addr    = fill_q.idx[AW-1:0];
        wr_data    = in_data;
        commit     = fire && in_last && !drop_eff;
        commit_len = len_eff;
        err        = fill_q.err;
        if (fire) begin
            fill_d.len  = len_eff;
            fill_d.drop = drop_eff;
            if (drop_eff) begin
                fill_d.err = 1'b1;
            end
            if (in_last) begin
                fill_d.idx = '0;
                if (!drop_eff) begin
                    fill_d.bank = ~fill_q.bank;
                end
            end else if (fill_q.idx < CW'(MAX_WORDS)) begin
                fill_d.idx = fill_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/opconv_store.sv
module opconv_store
    import opconv_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int LEN_W     = 9,
    parameter int AW        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_addr,
    input  word_t            wr_data,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             free_bank,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_addr_hi,
    input  logic [AW-1:0]    rd_addr_lo,
    output logic [1:0]       bank_full,
    output logic [LEN_W-1:0] rd_len,
    output word_t            rd_hi,
    output word_t            rd_lo
);
    typedef struct packed {
        logic [1:0]            full;
        logic [1:0][LEN_W-1:0] len;
    } store_t;

    store_t store_q, store_d;
    word_t  mem [2][MAX_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_bank][wr_addr] <= wr_data;
        end
    end

    always_comb begin
        store_d = store_q;
        if (commit) begin
            store_d.full[wr_bank] = 1'b1;
            store_d.len[wr_bank]  = commit_len;
        end
        if (free_bank) begin
            store_d.full[rd_bank] = 1'b0;
        end
        bank_full = store_q.full;
        rd_len    = store_q.len[rd_bank];
        rd_hi     = mem[rd_bank][rd_addr_hi];
        rd_lo     = mem[rd_bank][rd_addr_lo];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    // R6
    no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || commit) |-> !store_q.full[wr_bank]);

endmodule

// File: rtl/opconv_drain.sv
module opconv_drain
    import opconv_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int LEN_W     = 9,
    parameter int AW        = 5,
    parameter int CW        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bank_full,
    input  logic [LEN_W-1:0] rd_len,
    input  word_t            rd_hi,
    input  word_t            rd_lo,
    input  logic             out_ready,
    output logic             out_valid,
    output word_t            out_data,
    output logic             out_last,
    output logic             rd_bank,
    output logic [AW-1:0]    rd_addr_hi,
    output logic [AW-1:0]    rd_addr_lo,
    output logic             free_bank
);
    typedef struct packed {
        logic          bank;
        logic [CW-1:0] widx;
    } drain_t;

    drain_t                  drain_q, drain_d;
    logic [CW-1:0]           nwords;
    logic [CW-1:0]           src_idx;
    logic                    lo_ok;
    logic [5:0]              shamt;
    logic [2*WORD_BITS-1:0]  pair;
    word_t                   window;

    always_comb begin
        drain_d    = drain_q;
        nwords     = CW'(({1'b0, rd_len} + (LEN_W+1)'(7)) >> 3);
        src_idx    = nwords - drain_q.widx - 1'b1;
        rd_addr_hi = src_idx[AW-1:0];
        rd_addr_lo = rd_addr_hi - 1'b1;
        lo_ok      = (src_idx != '0);
        shamt      = {3'(3'd0 - rd_len[2:0]), 3'b000};
        pair       = {(lo_ok ? rd_lo : '0), rd_hi};
        window     = WORD_BITS'(pair >> shamt);
        out_data   = byte_rev(window);
        rd_bank    = drain_q.bank;
        out_valid  = bank_full[drain_q.bank];
        out_last   = (drain_q.widx == nwords - 1'b1);
        free_bank  = out_valid && out_ready && out_last;
        if (out_valid && out_ready) begin
            if (out_last) begin
                drain_d.widx = '0;
                drain_d.bank = ~drain_q.bank;
            end else begin
                drain_d.widx = drain_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= '0;
        end else begin
            drain_q <= drain_d;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4
    more_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

endmodule

// File: rtl/opconv_top.sv
module opconv_top
    import opconv_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    localparam int MAX_BYTES = MAX_WORDS * 8,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int AW        = $clog2(MAX_WORDS),
    localparam int CW        = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [63:0]      in_data,
    input  logic             in_last,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_data,
    output logic             out_last,
    output logic             err
);
    logic             wr_en;
    logic             wr_bank;
    logic [AW-1:0]    wr_addr;
    word_t            wr_data;
    logic             commit;
    logic [LEN_W-1:0] commit_len;
    logic [1:0]       bank_full;
    logic             free_bank;
    logic             rd_bank;
    logic [AW-1:0]    rd_addr_hi;
    logic [AW-1:0]    rd_addr_lo;
    logic [LEN_W-1:0] rd_len;
    word_t            rd_hi;
    word_t            rd_lo;

    opconv_fill #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .AW(AW), .CW(CW)) u_fill (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_len(in_len), .bank_full(bank_full),
        .in_ready(in_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .commit_len(commit_len), .err(err)
    );

    opconv_store #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
        .commit_len(commit_len), .free_bank(free_bank), .rd_bank(rd_bank),
        .rd_addr_hi(rd_addr_hi), .rd_addr_lo(rd_addr_lo), .bank_full(bank_full),
        .rd_len(rd_len), .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    opconv_drain #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .AW(AW), .CW(CW)) u_drain (
        .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .rd_len(rd_len),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .rd_bank(rd_bank), .rd_addr_hi(rd_addr_hi), .rd_addr_lo(rd_addr_lo),
        .free_bank(free_bank)
    );

endmodule

// File: tb/opconv_top_bench.sv
module opconv_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LW = 9;
    localparam int NVEC = 8;
    localparam int VEC_LEN [NVEC] = '{8, 16, 13, 1, 7, 24, 129, 256};
    localparam int VEC_NW  [NVEC] = '{1, 2, 2, 1, 1, 3, 17, 32};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [63:0]   in_data = '0;
    logic          in_last = 1'b0;
    logic [LW-1:0] in_len = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [63:0]   out_data;
    logic          out_last;
    logic          err;

    int total = 0;
    int bad = 0;
    logic [7:0] refb [0:511];

    always #2.5 clk = ~clk;

    opconv_top u_opconv_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_len(in_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic fill_bytes(input int len, input int seed);
        for (int i = 0; i < 512; i++) refb[i] = (i < len) ? 8'(i * 37 + seed * 11 + 5) : 8'h00;
    endtask

    function automatic logic [63:0] mk_in(input int k, input int len);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[63-8*j -: 8] = ((8*k + j) < len) ? refb[8*k + j] : 8'hEE;
        return r;
    endfunction

    function automatic logic [63:0] mk_exp(input int w, input int len);
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[63-8*j -: 8] = ((8*w + j) < len) ? refb[len - 1 - (8*w + j)] : 8'h00;
        return r;
    endfunction

    task automatic put(input logic [63:0] d, input logic last, input int len);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        in_len   = LW'(len);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic get(output logic [63:0] d, output logic l);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        d = out_data;
        l = out_last;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
    endtask

    task automatic send_op(input int len, input int nw, input bit r5chk);
        for (int k = 0; k < nw; k++) begin
            put(mk_in(k, len), (k == nw - 1), len);
            if (r5chk && k != nw - 1) begin
                @(negedge clk);
                chk(out_valid == 1'b0, "R5 no output while loading", 64'(out_valid), 64'd0);
            end
        end
    endtask

    task automatic recv_op(input int len, input string tag);
        int nw;
        logic [63:0] d;
        logic l;
        nw = (len + 7) / 8;
        for (int w = 0; w < nw; w++) begin
            get(d, l);
            chk(d == mk_exp(w, len), tag, d, mk_exp(w, len));
            chk(l == (w == nw - 1), "R4 last flag", 64'(l), 64'(w == nw - 1));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic        l;
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(err == 1'b0, "R1 err", 64'(err), 64'd0);

        // R3 worked example, 13 bytes
        fill_bytes(0, 0);
        {refb[0], refb[1], refb[2], refb[3], refb[4], refb[5], refb[6]} = 56'h12abcdef123456;
        {refb[7], refb[8], refb[9], refb[10], refb[11], refb[12]} = 48'h789abcdef0f1;
        send_op(13, 2, 1'b1);
        get(d, l);
        chk(d == 64'hf1f0debc9a785634, "R3 example word0", d, 64'hf1f0debc9a785634);
        get(d, l);
        chk(d == 64'h12efcdab12000000, "R3 example word1", d, 64'h12efcdab12000000);
        chk(l == 1'b1, "R4 example last", 64'(l), 64'd1);

        // R2 R3 R9 vector table walk
        for (int v = 0; v < NVEC; v++) begin
            fill_bytes(VEC_LEN[v], v + 1);
            send_op(VEC_LEN[v], VEC_NW[v], 1'b1);
            recv_op(VEC_LEN[v], (VEC_LEN[v] % 8 == 0) ? "R2 R9 aligned reversal" : "R3 unaligned reversal");
        end

        // R6 double buffering, R8 stall hold
        fill_bytes(16, 20);
        send_op(16, 2, 1'b0);
        fill_bytes(8, 21);
        send_op(8, 1, 1'b0);
        @(negedge clk);
        chk(in_ready == 1'b0, "R6 both buffers full", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b1, "R6 first operand ready", 64'(out_valid), 64'd1);
        held = out_data;
        repeat (3) @(negedge clk);
        chk(out_data == held, "R8 data held in stall", out_data, held);
        chk(out_valid == 1'b1, "R8 valid held in stall", 64'(out_valid), 64'd1);
        fill_bytes(16, 20);
        recv_op(16, "R6 older operand");
        @(negedge clk);
        chk(in_ready == 1'b1, "R6 buffer freed", 64'(in_ready), 64'd1);
        fill_bytes(8, 21);
        recv_op(8, "R6 newer operand");

        // R7 illegal lengths
        fill_bytes(0, 0);
        send_op(0, 1, 1'b0);
        @(negedge clk);
        chk(err == 1'b1, "R7 zero length flags", 64'(err), 64'd1);
        fill_bytes(300, 30);
        send_op(300, 2, 1'b0);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R7 no output for bad length", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R7 input still accepted", 64'(in_ready), 64'd1);
        fill_bytes(8, 31);
        send_op(8, 1, 1'b0);
        recv_op(8, "R7 good operand after error");
        chk(err == 1'b1, "R7 err sticky", 64'(err), 64'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule